// File: doc/BRIEF.md
# Instruction Fetch Unit with Run Control

This block is the front end of a small processor. It repeatedly fetches 16-bit instruction words from a 4096-word read-only program store into an instruction register, so that a downstream decoder can act on them. Inside are a program counter, an address register that drives the program store, a buffer register that captures the word read back, and the instruction register. A three-step sequencer drives the load and increment strobes for these registers. Each step is split into four sub-phases, so one complete fetch takes twelve clock cycles.

A run flip-flop gates the sequencer. While idle, the block waits for a rising edge on the power-on input and ignores the halt input. While running, it waits for a rising edge on the halt input, which the decoder raises, and ignores power-on. Every start of a run clears the program counter and the sequencer, so the stored program always executes again from address 0. The program store sits outside the block and has a one-cycle registered read. The instruction register and its upper four bits (the opcode field) are exported for observation.

Top module: `fetch_runctl`

## Requirements
- R1: After synchronous reset, `run_o` is 0, `ir_o` is 0, `opcode_o` is 0 and `mem_addr_o` is 0.
- R2: While idle, a rising edge of `pwr_on` (1 sampled at an edge, 0 at the edge before) sets `run_o` to 1 at that clock edge. A `pwr_on` level held high after a halt does not start a new run.
- R3: While running, a rising edge of `halt` clears `run_o` at that clock edge. A `halt` level that was already high when the run started does not stop it.
- R4: While idle, `halt` has no effect: `run_o`, `ir_o` and `mem_addr_o` stay unchanged.
- R5: While running, a rising edge of `pwr_on` has no effect, and fetching continues at the next sequential address without clearing the program counter.
- R6: Every run start clears the program counter, the step counter and the phase counter, including after a halt in the middle of a fetch. The first word fetched is therefore the word at address 0.
- R7: With the edge that starts the run counted as edge 0, the address register loads the program counter at the last sub-phase of step 0. The program counter increments at sub-phase 0 of step 1. The buffer register captures the read data at the last sub-phase of step 1, and the instruction register loads the buffer at the last sub-phase of step 2. Fetch k therefore appears on `ir_o` at edge 12k+12 and stays there through edge 12k+23.
- R8: Fetch k reads address k modulo 4096 (`mem_addr_o` equals k[11:0] from the address load onwards), so the address wraps from 4095 to 0.
- R9: `opcode_o` equals bits 15:12 of the instruction register.
- R10: While idle, the program counter, the step counter and the phase counter hold their values, and `ir_o` and `mem_addr_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on | input | 1 | Start request; its rising edge starts a run while idle |
| halt | input | 1 | Stop strobe from the decoder; its rising edge stops a run |
| mem_addr_o | output | 12 | Program store address (the address register) |
| mem_rdata_i | input | 16 | Program store read data, valid one cycle after the address |
| run_o | output | 1 | Run flip-flop state |
| ir_o | output | 16 | Instruction register |
| opcode_o | output | 4 | Opcode field, bits 15:12 of the instruction register |

## Verification
`run_o` changes at the same clock edge that samples a qualifying edge on `pwr_on` or `halt`. The bench drives these inputs on falling edges and reads `run_o` on the next falling edge. Fetch k lands in `ir_o` exactly twelve edges after fetch k-1, and the first fetch lands twelve edges after the start edge. The bench therefore counts twelve falling edges per fetch and compares against a word it computes from the address, with the store read modelled with its one-cycle latency. One extra sample, one edge before the first load, confirms that the instruction register has not yet moved. The halt and restart cases land at arbitrary sub-phases, so the same twelve-edge spacing after each restart shows that the sequencer was cleared.

// File: rtl/fetch_runctl_pkg.sv
package fetch_runctl_pkg;

    // The fetch schedule has a fixed number of steps.
    localparam int NSTEP  = 3;
    localparam int STEP_W = 2;

    // Run flip-flop state with the input history used for edge detection.
    typedef struct packed {
        logic run;
        logic run_prev;
        logic pon_prev;
        logic halt_prev;
    } run_st_t;

endpackage

// File: rtl/fetch_runctl_runff.sv
module fetch_runctl_runff
    import fetch_runctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_on,
    input  logic halt,
    output logic run,
    output logic arm,
    output logic run_start,
    output logic pon_prev,
    output logic halt_prev
);

    run_st_t st_d, st_q;
    logic    pon_rise, halt_rise;

    always_comb begin
        st_d           = st_q;
        pon_rise       = pwr_on & ~st_q.pon_prev;
        halt_rise      = halt & ~st_q.halt_prev;
        st_d.pon_prev  = pwr_on;
        st_d.halt_prev = halt;
        st_d.run_prev  = st_q.run;
        if (!st_q.run) begin
            if (pon_rise) st_d.run = 1'b1;
        end else begin
            if (halt_rise) st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign run       = st_q.run;
    assign arm       = ~st_q.run & pwr_on & ~st_q.pon_prev;
    assign run_start = st_q.run & ~st_q.run_prev;
    assign pon_prev  = st_q.pon_prev;
    assign halt_prev = st_q.halt_prev;

endmodule

// File: rtl/fetch_runctl_seq.sv
module fetch_runctl_seq
    import fetch_runctl_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    output logic [STEP_W-1:0] step,
    output logic [PH_W-1:0]   phase
);

    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'((1 << PH_W) - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEP - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [PH_W-1:0]   phase;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else if (run) begin
            st_d.phase = st_q.phase + PH_W'(1);
            if (st_q.phase == PH_LAST) begin
                st_d.step = (st_q.step == STEP_LAST) ? '0 : st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign step  = st_q.step;
    assign phase = st_q.phase;

endmodule

// File: rtl/fetch_runctl_dp.sv
module fetch_runctl_dp
    import fetch_runctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int PH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr_pc,
    input  logic [STEP_W-1:0] step,
    input  logic [PH_W-1:0]   phase,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] ir
);

    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'((1 << PH_W) - 1);
    localparam logic [STEP_W-1:0] ST_ADDR   = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_READ   = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_LOAD   = STEP_W'(2);

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
    } dp_st_t;

    dp_st_t st_d, st_q;
    logic   mar_ld, pc_inc, mbr_ld, ir_ld;

    always_comb begin
        mar_ld = run && (step == ST_ADDR) && (phase == PH_LAST);
        pc_inc = run && (step == ST_READ) && (phase == '0);
        mbr_ld = run && (step == ST_READ) && (phase == PH_LAST);
        ir_ld  = run && (step == ST_LOAD) && (phase == PH_LAST);

        st_d = st_q;
        if (clr_pc)      st_d.pc = '0;
        else if (pc_inc) st_d.pc = st_q.pc + DATA_W'(1);
        if (mar_ld) st_d.mar = st_q.pc[ADDR_W-1:0];
        if (mbr_ld) st_d.mbr = mem_rdata;
        if (ir_ld)  st_d.ir  = st_q.mbr;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mem_addr = st_q.mar;
    assign ir       = st_q.ir;

endmodule

// File: rtl/fetch_runctl.sv
module fetch_runctl
    import fetch_runctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    parameter int PH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic              halt,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              run_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [OPC_W-1:0]  opcode_o
);

    logic              run, arm, run_start, pon_prev, halt_prev;
    logic [STEP_W-1:0] step;
    logic [PH_W-1:0]   phase;

    fetch_runctl_runff u_run (
        .clk       (clk),
        .rst       (rst),
        .pwr_on    (pwr_on),
        .halt      (halt),
        .run       (run),
        .arm       (arm),
        .run_start (run_start),
        .pon_prev  (pon_prev),
        .halt_prev (halt_prev)
    );

    fetch_runctl_seq #(.PH_W(PH_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (arm),
        .step    (step),
        .phase   (phase)
    );

    fetch_runctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PH_W(PH_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .clr_pc    (run_start),
        .step      (step),
        .phase     (phase),
        .mem_rdata (mem_rdata_i),
        .mem_addr  (mem_addr_o),
        .ir        (ir_o)
    );

    assign run_o    = run;
    assign opcode_o = ir_o[DATA_W-1 -: OPC_W];

endmodule

// File: rtl/fetch_runctl_chk.sv
module fetch_runctl_chk
    import fetch_runctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int PH_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_on,
    input logic              halt,
    input logic              pon_prev,
    input logic              halt_prev,
    input logic              run,
    input logic [DATA_W-1:0] ir,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [STEP_W-1:0] step,
    input logic [PH_W-1:0]   phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'((1 << PH_W) - 1);

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!run && pwr_on && !pon_prev) |=> run);                          // R2
    AST_STOP_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (run && halt && !halt_prev) |=> !run);                           // R3
    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !(pwr_on && !pon_prev)) |=> !run);                      // R4
    AST_RUN_STAYS_RUN: assert property (@(posedge clk) disable iff (rst)
        (run && !(halt && !halt_prev)) |=> run);                         // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(ir) && $stable(mem_addr)));                    // R10
    AST_IR_LOAD_SLOT: assert property (@(posedge clk) disable iff (rst)
        !$stable(ir) |-> ($past(step) == STEP_W'(2) && $past(phase) == PH_LAST)); // R7
    AST_ADDR_LOAD_SLOT: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> ($past(step) == STEP_W'(0) && $past(phase) == PH_LAST)); // R7

endmodule

bind fetch_runctl fetch_runctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PH_W(PH_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_on    (pwr_on),
    .halt      (halt),
    .pon_prev  (pon_prev),
    .halt_prev (halt_prev),
    .run       (run_o),
    .ir        (ir_o),
    .mem_addr  (mem_addr_o),
    .step      (step),
    .phase     (phase)
);

// File: tb/fetch_runctl_tb_top.sv
module fetch_runctl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_on = 1'b0;
    logic        halt = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        run;
    logic [15:0] ir;
    logic [3:0]  opcode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fetch_runctl dut_i (
        .clk         (clk),
        .rst         (rst),
        .pwr_on      (pwr_on),
        .halt        (halt),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .run_o       (run),
        .ir_o        (ir),
        .opcode_o    (opcode)
    );

    // Program store contents, distinct for every address and nonzero at 0.
    function automatic logic [15:0] rom(input logic [11:0] a);
        return {a[3:0] ^ a[7:4], a ^ 12'hA53};
    endfunction

    // Store model with a one-cycle registered read.
    always_ff @(posedge clk) mem_rdata <= rom(mem_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Start a run: pwr_on low for one edge, then high. Check run one edge later.
    task automatic start_run(input string tag);
        @(negedge clk); pwr_on = 1'b0;
        @(negedge clk); pwr_on = 1'b1;
        @(negedge clk);
        chk({tag, " run after start edge"}, 32'(run), 32'd1);
    endtask

    // Wait for fetch k and check it (sampled at the falling edge after edge 12k+12).
    task automatic fetch_check(input int k, input string tag);
        for (int c = 0; c < 12; c++) @(negedge clk);
        chk({tag, " ir"}, 32'(ir), 32'(rom(12'(k))));
        chk("R9 opcode", 32'(opcode), 32'(rom(12'(k)) >> 12));
        chk("R8 mem_addr", 32'(mem_addr), 32'(k % 4096));
    endtask

    initial begin
        logic [15:0] ir_hold;
        logic [11:0] addr_hold;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 run", 32'(run), 32'd0);
        chk("R1 ir", 32'(ir), 32'd0);
        chk("R1 opcode", 32'(opcode), 32'd0);
        chk("R1 mem_addr", 32'(mem_addr), 32'd0);

        // R4: halt pulses while idle.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); halt = 1'b1;
            @(negedge clk); halt = 1'b0;
        end
        @(negedge clk);
        chk("R4 run idle after halt", 32'(run), 32'd0);
        chk("R4 ir idle after halt", 32'(ir), 32'd0);

        // R2 / R7: first run, first-load timing.
        start_run("R2");
        for (int c = 0; c < 11; c++) @(negedge clk);
        chk("R7 ir not loaded before edge 12", 32'(ir), 32'd0);
        chk("R7 address loaded at step 0", 32'(mem_addr), 32'd0);
        @(negedge clk);
        chk("R7 first fetch ir", 32'(ir), 32'(rom(12'd0)));

        // R8: sequential fetch across the wrap; R5: pwr_on edge mid-run.
        for (int k = 1; k < 4100; k++) begin
            if (k == 50) begin
                for (int c = 0; c < 12; c++) begin
                    @(negedge clk);
                    if (c == 2) pwr_on = 1'b0;
                    if (c == 4) pwr_on = 1'b1;
                end
                chk("R5 ir continues", 32'(ir), 32'(rom(12'(k))));
                chk("R5 run", 32'(run), 32'd1);
            end else begin
                fetch_check(k, "R8");
            end
        end

        // R3: halt rising edge stops the run.
        halt = 1'b1;
        @(negedge clk);
        chk("R3 run after halt", 32'(run), 32'd0);
        ir_hold   = ir;
        addr_hold = mem_addr;

        // R10 / R2 / R4: idle with pwr_on held high and halt toggling.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); halt = 1'b0;
            @(negedge clk); halt = 1'b1;
        end
        halt = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 held pwr_on no restart", 32'(run), 32'd0);
        chk("R10 ir held", 32'(ir), 32'(ir_hold));
        chk("R10 mem_addr held", 32'(mem_addr), 32'(addr_hold));

        // R6: restart begins at address 0.
        start_run("R6");
        for (int k = 0; k < 3; k++) fetch_check(k, "R6 restart");

        // R6: halt in the middle of a fetch, then restart with halt held high.
        repeat (5) @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        chk("R3 mid-fetch halt", 32'(run), 32'd0);
        start_run("R3 halt level held");
        for (int k = 0; k < 4; k++) fetch_check(k, "R6 mid-step restart");
        chk("R3 run with halt level high", 32'(run), 32'd1);
        @(negedge clk); halt = 1'b0;
        @(negedge clk); halt = 1'b1;
        @(negedge clk);
        chk("R3 second halt edge", 32'(run), 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule